// File: doc/BRIEF.md
# Banked Control Register File

This block keeps the control registers of a small processor core and serves them by register number. A single write port takes a register number and a 32-bit value. A combinational read port returns the value of the register whose number is on its address input. The register set is a packed status word, a standalone condition-bit view, a second-level backup status byte, two backup program counters, two scratch registers, and a pair of stack-pointer banks, one for interrupt mode and one for user mode.

The core's live stack pointer is held here and is the block's only other output. The core can also overwrite it through a dedicated write port. Bit 7 of the current status byte selects the stack mode. When a status write changes that bit, the live pointer is saved into the bank of the mode being left and reloaded from the bank of the mode being entered, both in one clock edge. An access by number to the bank of the current mode reaches the live pointer. An access to the other bank reaches its stored copy.

Top module: `ctl_bank_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register, including the live stack pointer and both banks, and leaves interrupt-stack mode (status bit 7 clear) active.
- R2: Register 0 (status) reads as {16'b0, backup_status & 8'hC1, current_status & 8'hC0} with the condition bit ORed into bit 0; no other bit can ever read as one.
- R3: A write to register 0 loads the backup status byte from data bits 15:8, the current status byte from bits 7:0, and the condition bit from bit 0.
- R4: Register 1 reads as the condition bit alone in bit 0, and a write to it changes only the condition bit, taken from data bit 0.
- R5: A write to register 0 whose bit 7 differs from the current stack-mode bit stores the live pointer into the bank being left and loads the live pointer from the bank being entered; bit 7 clear is interrupt mode, set is user mode.
- R6: A write to register 0 that keeps bit 7 unchanged leaves the live pointer and both banks as they were.
- R7: Register 2 is the interrupt-stack bank and register 3 the user-stack bank; reads and writes of the bank matching the current mode go to the live pointer, and those of the other bank go to its stored copy.
- R8: The core stack-pointer write port loads the live pointer, except in a cycle where a control write also changes the live pointer (a mode swap or a write to the active bank), in which case the control write wins.
- R9: Registers 6 and 9 (backup program counters) store all 32 written bits but read with bit 0 forced to zero.
- R10: Register 8 (second-level backup status) stores data bits 7:0 and reads as that byte ANDed with 8'hC1.
- R11: Registers 4 and 5 are plain 32-bit storage that reads back exactly what was written, with no side effect.
- R12: Register numbers 7 and 10 to 15 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_num | input | 4 | Register number of the write |
| wr_data | input | 32 | Write data |
| rd_num | input | 4 | Register number of the combinational read |
| rd_data | output | 32 | Read data for rd_num |
| sp_wr_en | input | 1 | Core write strobe for the live stack pointer |
| sp_wr_data | input | 32 | Core value for the live stack pointer |
| sp_live | output | 32 | Live stack pointer |

## Verification
The main sweep writes each of the sixteen register numbers with several arithmetic bit patterns. After every write, all sixteen registers and the live pointer are read back. Patterns with all ones and with zeros expose masking faults in the status, backup status and backup counter reads. Patterns that flip bit 7 of the status byte drive the stack bank swaps in both directions, and writes to registers 2 and 3 under each mode separate the live-pointer path from the stored copy. Directed sequences place a core pointer write in the same cycle as a swap, as an active-bank write and as an inactive-bank write, which tells apart the priority of the two write ports.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int XLEN      = 32;
    localparam int NUM_W     = 4;
    localparam int N_SCRATCH = 2;
    localparam int BYTE_W    = 8;
    localparam int MODE_BIT  = 7;

    // register numbers
    localparam int CR_STATUS = 0;
    localparam int CR_COND   = 1;
    localparam int CR_SP_INT = 2;
    localparam int CR_SP_USR = 3;
    localparam int CR_SCR0   = 4;
    localparam int CR_BPC    = 6;
    localparam int CR_BBST   = 8;
    localparam int CR_BBPC   = 9;

    localparam logic [BYTE_W-1:0] CUR_RD_MASK = 8'hC0;
    localparam logic [BYTE_W-1:0] BAK_RD_MASK = 8'hC1;

    typedef enum logic {
        SM_INT = 1'b0,
        SM_USR = 1'b1
    } stack_mode_e;

    typedef struct packed {
        logic                 status;
        logic                 cond;
        logic                 sp_int;
        logic                 sp_usr;
        logic                 bpc;
        logic                 bbst;
        logic                 bbpc;
        logic [N_SCRATCH-1:0] scr;
    } cr_sel_s;

    function automatic cr_sel_s cr_select(input logic [NUM_W-1:0] n);
        cr_sel_s s;
        int      k;
        s = '0;
        k = int'(n);
        s.status = (k == CR_STATUS);
        s.cond   = (k == CR_COND);
        s.sp_int = (k == CR_SP_INT);
        s.sp_usr = (k == CR_SP_USR);
        s.bpc    = (k == CR_BPC);
        s.bbst   = (k == CR_BBST);
        s.bbpc   = (k == CR_BBPC);
        for (int i = 0; i < N_SCRATCH; i++) begin
            s.scr[i] = (k == CR_SCR0 + i);
        end
        return s;
    endfunction

    function automatic logic [XLEN-1:0] status_pack(
        input logic [BYTE_W-1:0] bak,
        input logic [BYTE_W-1:0] cur,
        input logic              cond
    );
        logic [XLEN-1:0] v;
        v = '0;
        v[2*BYTE_W-1:BYTE_W] = bak & BAK_RD_MASK;
        v[BYTE_W-1:0]        = (cur & CUR_RD_MASK) | {{(BYTE_W-1){1'b0}}, cond};
        return v;
    endfunction

endpackage

// File: rtl/ctlreg_status.sv
module ctlreg_status
    import ctlreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                st_we,
    input  logic                cond_we,
    input  logic [2*BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0]   cur_q,
    output logic [BYTE_W-1:0]   bak_q,
    output logic                cond_q,
    output stack_mode_e         mode_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            bak_q  <= '0;
            cond_q <= 1'b0;
        end else if (st_we) begin
            bak_q  <= wdata[2*BYTE_W-1:BYTE_W];
            cur_q  <= wdata[BYTE_W-1:0];
            cond_q <= wdata[0];
        end else if (cond_we) begin
            cond_q <= wdata[0];
        end
    end

    assign mode_o = stack_mode_e'(cur_q[MODE_BIT]);

endmodule

// File: rtl/ctlreg_stack.sv
module ctlreg_stack
    import ctlreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  stack_mode_e     mode,
    input  logic            st_we,
    input  stack_mode_e     new_mode,
    input  logic            int_we,
    input  logic            usr_we,
    input  logic [XLEN-1:0] wdata,
    input  logic            sp_we,
    input  logic [XLEN-1:0] sp_wdata,
    output logic [XLEN-1:0] live_q,
    output logic [XLEN-1:0] bank_int_q,
    output logic [XLEN-1:0] bank_usr_q
);

    logic swap;
    logic live_ctl;

    assign swap     = st_we && (new_mode != mode);
    assign live_ctl = (int_we && mode == SM_INT) || (usr_we && mode == SM_USR);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q     <= '0;
            bank_int_q <= '0;
            bank_usr_q <= '0;
        end else if (swap) begin
            if (mode == SM_INT) begin
                bank_int_q <= live_q;
                live_q     <= bank_usr_q;
            end else begin
                bank_usr_q <= live_q;
                live_q     <= bank_int_q;
            end
        end else begin
            if (int_we && mode == SM_USR) bank_int_q <= wdata;
            if (usr_we && mode == SM_INT) bank_usr_q <= wdata;
            if (live_ctl)   live_q <= wdata;
            else if (sp_we) live_q <= sp_wdata;
        end
    end

endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
    import ctlreg_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bpc_we,
    input  logic                           bbpc_we,
    input  logic                           bbst_we,
    input  logic [N_SCRATCH-1:0]           scr_we,
    input  logic [XLEN-1:0]                wdata,
    output logic [XLEN-1:0]                bpc_q,
    output logic [XLEN-1:0]                bbpc_q,
    output logic [BYTE_W-1:0]              bbst_q,
    output logic [N_SCRATCH-1:0][XLEN-1:0] scr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bpc_q  <= '0;
            bbpc_q <= '0;
            bbst_q <= '0;
        end else begin
            if (bpc_we)  bpc_q  <= wdata;
            if (bbpc_we) bbpc_q <= wdata;
            if (bbst_we) bbst_q <= wdata[BYTE_W-1:0];
        end
    end

    for (genvar g = 0; g < N_SCRATCH; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (rst)            scr_q[g] <= '0;
            else if (scr_we[g]) scr_q[g] <= wdata;
        end
    end

endmodule

// File: rtl/ctl_bank_regfile.sv
module ctl_bank_regfile
    import ctlreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [NUM_W-1:0] wr_num,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [NUM_W-1:0] rd_num,
    output logic [XLEN-1:0]  rd_data,
    input  logic             sp_wr_en,
    input  logic [XLEN-1:0]  sp_wr_data,
    output logic [XLEN-1:0]  sp_live
);

    cr_sel_s                        wsel;
    cr_sel_s                        rsel;
    logic [BYTE_W-1:0]              cur_q;
    logic [BYTE_W-1:0]              bak_q;
    logic                           cond_q;
    stack_mode_e                    mode_q;
    logic [XLEN-1:0]                bank_int;
    logic [XLEN-1:0]                bank_usr;
    logic [XLEN-1:0]                bpc_q;
    logic [XLEN-1:0]                bbpc_q;
    logic [BYTE_W-1:0]              bbst_q;
    logic [N_SCRATCH-1:0][XLEN-1:0] scr_q;

    assign wsel = wr_en ? cr_select(wr_num) : '0;
    assign rsel = cr_select(rd_num);

    ctlreg_status u_status (
        .clk     (clk),
        .rst     (rst),
        .st_we   (wsel.status),
        .cond_we (wsel.cond),
        .wdata   (wr_data[2*BYTE_W-1:0]),
        .cur_q   (cur_q),
        .bak_q   (bak_q),
        .cond_q  (cond_q),
        .mode_o  (mode_q)
    );

    ctlreg_stack u_stack (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_q),
        .st_we      (wsel.status),
        .new_mode   (stack_mode_e'(wr_data[MODE_BIT])),
        .int_we     (wsel.sp_int),
        .usr_we     (wsel.sp_usr),
        .wdata      (wr_data),
        .sp_we      (sp_wr_en),
        .sp_wdata   (sp_wr_data),
        .live_q     (sp_live),
        .bank_int_q (bank_int),
        .bank_usr_q (bank_usr)
    );

    ctlreg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .bpc_we  (wsel.bpc),
        .bbpc_we (wsel.bbpc),
        .bbst_we (wsel.bbst),
        .scr_we  (wsel.scr),
        .wdata   (wr_data),
        .bpc_q   (bpc_q),
        .bbpc_q  (bbpc_q),
        .bbst_q  (bbst_q),
        .scr_q   (scr_q)
    );

    always_comb begin
        rd_data = '0;
        if (rsel.status) rd_data = status_pack(bak_q, cur_q, cond_q);
        if (rsel.cond)   rd_data = {{(XLEN-1){1'b0}}, cond_q};
        if (rsel.sp_int) rd_data = (mode_q == SM_INT) ? sp_live : bank_int;
        if (rsel.sp_usr) rd_data = (mode_q == SM_USR) ? sp_live : bank_usr;
        if (rsel.bpc)    rd_data = {bpc_q[XLEN-1:1], 1'b0};
        if (rsel.bbpc)   rd_data = {bbpc_q[XLEN-1:1], 1'b0};
        if (rsel.bbst)   rd_data = {{(XLEN-BYTE_W){1'b0}}, bbst_q & BAK_RD_MASK};
        for (int i = 0; i < N_SCRATCH; i++) begin
            if (rsel.scr[i]) rd_data = scr_q[i];
        end
    end

endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk
    import ctlreg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [NUM_W-1:0] wr_num,
    input logic [XLEN-1:0]  wr_data,
    input logic [NUM_W-1:0] rd_num,
    input logic [XLEN-1:0]  rd_data,
    input logic             sp_wr_en,
    input logic [XLEN-1:0]  sp_wr_data,
    input logic [XLEN-1:0]  sp_live,
    input logic             mode,
    input logic [XLEN-1:0]  bank_int,
    input logic [XLEN-1:0]  bank_usr
);

    logic st_wr;
    assign st_wr = wr_en && (int'(wr_num) == CR_STATUS);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (sp_live == '0));

    assert_status_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_num) == CR_STATUS) |-> ((rd_data & ~32'h0000C1C1) == '0));

    assert_swap_to_usr_R5: assert property (@(posedge clk) disable iff (rst)
        (st_wr && wr_data[MODE_BIT] && !mode) |=> (sp_live == $past(bank_usr)));

    assert_swap_to_int_R5: assert property (@(posedge clk) disable iff (rst)
        (st_wr && !wr_data[MODE_BIT] && mode) |=> (sp_live == $past(bank_int)));

    assert_no_swap_R6: assert property (@(posedge clk) disable iff (rst)
        (st_wr && (wr_data[MODE_BIT] == mode) && !sp_wr_en) |=> $stable(sp_live));

    assert_core_sp_R8: assert property (@(posedge clk) disable iff (rst)
        (sp_wr_en && !wr_en) |=> (sp_live == $past(sp_wr_data)));

    assert_bpc_lsb_R9: assert property (@(posedge clk) disable iff (rst)
        ((int'(rd_num) == CR_BPC) || (int'(rd_num) == CR_BBPC)) |-> !rd_data[0]);

    assert_unassigned_R12: assert property (@(posedge clk) disable iff (rst)
        (cr_select(rd_num) == '0) |-> (rd_data == '0));

endmodule

bind ctl_bank_regfile ctlreg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_num     (wr_num),
    .wr_data    (wr_data),
    .rd_num     (rd_num),
    .rd_data    (rd_data),
    .sp_wr_en   (sp_wr_en),
    .sp_wr_data (sp_wr_data),
    .sp_live    (sp_live),
    .mode       (mode_q),
    .bank_int   (bank_int),
    .bank_usr   (bank_usr)
);

// File: tb/ctl_bank_regfile_bench.sv
module ctl_bank_regfile_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_num = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_num = '0;
    logic [31:0] rd_data;
    logic        sp_wr_en = 1'b0;
    logic [31:0] sp_wr_data = '0;
    logic [31:0] sp_live;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state
    logic [7:0]  m_cur, m_bak, m_bbst;
    logic        m_cond;
    logic [31:0] m_live, m_int, m_usr, m_bpc, m_bbpc, m_s4, m_s5;

    ctl_bank_regfile u_ctl_bank_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
        .rd_num(rd_num), .rd_data(rd_data), .sp_wr_en(sp_wr_en),
        .sp_wr_data(sp_wr_data), .sp_live(sp_live)
    );

    always #5 clk = ~clk;

    task automatic model_reset();
        m_cur = 0; m_bak = 0; m_bbst = 0; m_cond = 0;
        m_live = 0; m_int = 0; m_usr = 0; m_bpc = 0; m_bbpc = 0; m_s4 = 0; m_s5 = 0;
    endtask

    function automatic logic [31:0] exp_rd(input int n);
        case (n)
            0: return {16'h0, m_bak & 8'hC1, (m_cur & 8'hC0) | {7'h0, m_cond}};
            1: return {31'h0, m_cond};
            2: return m_cur[7] ? m_int : m_live;
            3: return m_cur[7] ? m_live : m_usr;
            4: return m_s4;
            5: return m_s5;
            6: return m_bpc & 32'hFFFF_FFFE;
            8: return {24'h0, m_bbst & 8'hC1};
            9: return m_bbpc & 32'hFFFF_FFFE;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input int n);
        case (n)
            0: return "R2";
            1: return "R4";
            2, 3: return "R7";
            4, 5: return "R11";
            6, 9: return "R9";
            8: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic model_step(input bit we, input int n, input logic [31:0] d,
                              input bit swe, input logic [31:0] sd);
        logic mode, swap, live_ctl;
        logic [31:0] live0;
        mode = m_cur[7];
        live0 = m_live;
        swap = we && n == 0 && d[7] != mode;
        live_ctl = we && ((n == 2 && !mode) || (n == 3 && mode));
        if (swap) begin
            if (!mode) begin m_int = live0; m_live = m_usr; end
            else       begin m_usr = live0; m_live = m_int; end
        end else begin
            if (we && n == 2 && mode)  m_int = d;
            if (we && n == 3 && !mode) m_usr = d;
            if (live_ctl) m_live = d;
            else if (swe) m_live = sd;
        end
        if (we) begin
            case (n)
                0: begin m_bak = d[15:8]; m_cur = d[7:0]; m_cond = d[0]; end
                1: m_cond = d[0];
                4: m_s4 = d;
                5: m_s5 = d;
                6: m_bpc = d;
                8: m_bbst = d[7:0];
                9: m_bbpc = d;
                default: ;
            endcase
        end
    endtask

    task automatic step(input bit we, input int n, input logic [31:0] d,
                        input bit swe, input logic [31:0] sd);
        @(negedge clk);
        wr_en = we; wr_num = 4'(n); wr_data = d;
        sp_wr_en = swe; sp_wr_data = sd;
        @(posedge clk);
        model_step(we, n, d, swe, sd);
        @(negedge clk);
        wr_en = 0; sp_wr_en = 0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic chk_reg(input int n, input string req);
        rd_num = 4'(n);
        #1;
        chk(req, rd_data, exp_rd(n), $sformatf("read reg %0d", n));
    endtask

    task automatic chk_all(input string req_override);
        for (int n = 0; n < 16; n++) begin
            chk_reg(n, (req_override == "") ? req_of(n) : req_override);
        end
        chk((req_override == "") ? "R7" : req_override, sp_live, m_live, "live sp");
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: everything cleared after reset
        chk_all("R1");

        // R3: status write fields
        step(1, 0, 32'h0000_C3C1, 0, 0);
        chk_reg(0, "R3");
        chk("R3", rd_data, 32'h0000_C1C1, "status packing");
        step(1, 0, 32'h0000_0000, 0, 0);

        // R4: condition register only touches the condition bit
        step(1, 0, 32'h0000_4040, 0, 0);
        step(1, 1, 32'hFFFF_FFFF, 0, 0);
        chk_reg(0, "R4");
        chk("R4", rd_data, 32'h0000_4041 & 32'h0000_C1C1 | 32'h1, "cond set");
        chk_reg(1, "R4");
        step(1, 1, 32'hFFFF_FFFE, 0, 0);
        chk_reg(0, "R4");

        // R5: swap sequence
        step(1, 0, 32'h0, 1, 32'h0000_1111);
        chk("R8", sp_live, 32'h0000_1111, "core sp write");
        step(1, 3, 32'h0000_2222, 0, 0);
        chk("R7", sp_live, 32'h0000_1111, "inactive user bank write");
        step(1, 0, 32'h0000_0080, 0, 0);
        chk("R5", sp_live, 32'h0000_2222, "swap to user");
        chk_reg(2, "R5");
        chk("R5", rd_data, 32'h0000_1111, "saved interrupt bank");
        chk_reg(3, "R5");
        // R6: same-mode status write keeps pointer
        step(1, 0, 32'h0000_C180, 0, 0);
        chk("R6", sp_live, 32'h0000_2222, "no swap");
        step(1, 0, 32'h0000_0000, 0, 0);
        chk("R5", sp_live, 32'h0000_1111, "swap to interrupt");
        chk_reg(3, "R5");
        chk("R5", rd_data, 32'h0000_2222, "saved user bank");

        // R8: port priority
        step(1, 0, 32'h0000_0080, 1, 32'hDEAD_0001);
        chk("R8", sp_live, 32'h0000_2222, "swap beats core write");
        step(1, 3, 32'h0000_3333, 1, 32'hDEAD_0002);
        chk("R8", sp_live, 32'h0000_3333, "active bank write beats core write");
        step(1, 2, 32'h0000_4444, 1, 32'h0000_5555);
        chk("R8", sp_live, 32'h0000_5555, "core write with inactive bank write");
        chk_all("R8");

        // R12: unassigned writes ignored
        for (int u = 10; u < 16; u++) begin
            step(1, u, 32'hFFFF_FFFF, 0, 0);
            chk_all("R12");
        end
        step(1, 7, 32'hFFFF_FFFF, 0, 0);
        chk_all("R12");

        // sweep: every register number with several patterns
        for (int p = 0; p < 6; p++) begin
            logic [31:0] pat;
            case (p)
                0: pat = 32'hFFFF_FFFF;
                1: pat = 32'h0000_0000;
                default: pat = 32'h9E37_79B9 * (p * 7 + 3) ^ (32'h0101_0101 << p);
            endcase
            for (int n = 0; n < 16; n++) begin
                step(1, n, pat ^ (32'h0000_0080 * (n & 1)), (n % 3) == 0, pat + 32'(n));
                chk_all("");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule